// File: doc/BRIEF.md
# Dual-Band Field Change Monitor

This block watches for an external reader field. It listens to two streams of converter readings, one from the low-frequency antenna path (LF) and one from the high-frequency path (HF). When monitoring starts, the first reading taken on each enabled band becomes that band's fixed baseline. That reading also becomes the band's moving reference.

Each later reading is compared with the moving reference. A jump of more than the threshold (10 counts by default) produces a change event. The event carries the previous reference, the new reading and the number of readings taken since the last change. The reference then moves to the new reading. A presence flag per band stays high while that band's reference sits more than the threshold away from its baseline.

A band-select mode chosen at start limits the work to one band or lets both run. A stop request ends monitoring. Each band's valid strobe is expected to stay low for at least one cycle between readings, which matches the pace of a shared converter.

Top module: `field_change_monitor`

## Requirements
- R1: A start request clears any earlier baseline and counter and latches `bandMode`. The first reading accepted afterwards on each enabled band becomes both its baseline and its reference, with counter 0 and no event. Readings that arrive in a cycle with a start or stop request are dropped.
- R2: `lfPresent`/`hfPresent` is high from the cycle after the reading that set the band's reference, for as long as |reference − baseline| > THRESH. A difference of exactly THRESH leaves the flag low.
- R3: Every accepted reading after the baseline adds one to the band's counter. The counter saturates at 2^CNT_W − 1.
- R4: A reading whose 11-bit unsigned difference from the reference exceeds THRESH raises `evtValid` for one cycle, in the cycle after the reading. The event carries `evtOldRef` (the reference), `evtNewRead` (the reading) and `evtCount` (the counter including this reading). A difference of exactly THRESH raises no event.
- R5: After an event, the reference becomes the new reading and the counter returns to 0. Later comparisons use the new reference, while the baseline stays fixed.
- R6: A stop request ends monitoring. From the next cycle both presence flags are low and readings are ignored until the next start. When start and stop come in the same cycle, stop wins.
- R7: `bandMode` encoding: 2'b01 runs the LF band only, 2'b10 runs the HF band only, and 2'b00 or 2'b11 run both. A disabled band produces no event and no presence.
- R8: `evtBand` is 0 for LF and 1 for HF. When both bands raise an event from the same cycle, the LF event is shown in the next cycle and the HF event in the cycle after.
- R9: After reset the block is idle. No event and no presence appear, and readings are ignored until a start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Begin or restart monitoring |
| stopReq | input | 1 | End monitoring |
| bandMode | input | 2 | Band selection, latched at start |
| lfSample | input | SAMPLE_W | LF reading |
| lfValid | input | 1 | LF reading strobe |
| hfSample | input | SAMPLE_W | HF reading |
| hfValid | input | 1 | HF reading strobe |
| lfPresent | output | 1 | LF field presence |
| hfPresent | output | 1 | HF field presence |
| evtValid | output | 1 | Change event strobe |
| evtBand | output | 1 | Band of the event (0 LF, 1 HF) |
| evtOldRef | output | SAMPLE_W | Reference before the change |
| evtNewRead | output | SAMPLE_W | Reading that caused the change |
| evtCount | output | CNT_W | Readings since the previous change |

## Verification
An event is due one cycle after the rising edge that takes the reading. The HF half of a coincident pair is due one cycle later. Presence and the effects of a start or stop are seen in the cycle after the request's edge. The bench drives inputs on the falling edge and advances its model on the rising edge. It then compares every output at the next falling edge, so each expectation lines up with the exact cycle its register delay gives.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam int NBANDS = 2;

  typedef enum logic [1:0] {
    MODE_BOTH    = 2'b00,
    MODE_LF_ONLY = 2'b01,
    MODE_HF_ONLY = 2'b10,
    MODE_BOTH_B  = 2'b11
  } bandMode_e;

  typedef struct packed {
    logic restart;  // clear baselines and counters
    logic hold;     // request cycle: readings dropped
    logic lfOn;     // LF band monitored
    logic hfOn;     // HF band monitored
  } ctlStrobe_t;
endpackage

// File: rtl/fcm_control.sv
module fcm_control
  import fcm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic [1:0] bandMode,
  output ctlStrobe_t strb
);
  logic      runQ;
  bandMode_e modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      modeQ <= MODE_BOTH;
    end else if (stopReq) begin
      runQ  <= 1'b0;
    end else if (startReq) begin
      runQ  <= 1'b1;
      modeQ <= bandMode_e'(bandMode);
    end
  end

  always_comb begin
    strb.restart = startReq && !stopReq;
    strb.hold    = startReq || stopReq;
    strb.lfOn    = runQ && (modeQ != MODE_HF_ONLY);
    strb.hfOn    = runQ && (modeQ != MODE_LF_ONLY);
  end
endmodule

// File: rtl/fcm_band.sv
module fcm_band #(
  parameter int SAMPLE_W = 10,
  parameter int CNT_W    = 16,
  parameter int THRESH   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  logic                accept,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                present,
  output logic                evtFire,
  output logic [SAMPLE_W-1:0] evtOld,
  output logic [SAMPLE_W-1:0] evtNew,
  output logic [CNT_W-1:0]    evtCount
);
  localparam int DIFF_W = SAMPLE_W + 1;
  localparam logic [DIFF_W-1:0] THR = DIFF_W'(THRESH);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                haveBaseQ;
  logic [SAMPLE_W-1:0] baseQ, refQ;
  logic [CNT_W-1:0]    cntQ, cntNext;
  logic [DIFF_W-1:0]   readDiff, presDiff;

  function automatic logic [DIFF_W-1:0] absDiff(input logic [SAMPLE_W-1:0] a,
                                                input logic [SAMPLE_W-1:0] b);
    logic [DIFF_W-1:0] ea, eb;
    ea = {1'b0, a};
    eb = {1'b0, b};
    return (ea >= eb) ? (ea - eb) : (eb - ea);
  endfunction

  always_comb begin
    readDiff = absDiff(sample, refQ);
    presDiff = absDiff(refQ, baseQ);
    cntNext  = (cntQ == CNT_MAX) ? cntQ : cntQ + 1'b1;
    evtFire  = accept && haveBaseQ && (readDiff > THR);
    evtOld   = refQ;
    evtNew   = sample;
    evtCount = cntNext;
    present  = haveBaseQ && (presDiff > THR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveBaseQ <= 1'b0;
      baseQ     <= '0;
      refQ      <= '0;
      cntQ      <= '0;
    end else if (clear) begin
      haveBaseQ <= 1'b0;
      cntQ      <= '0;
    end else if (accept) begin
      if (!haveBaseQ) begin
        haveBaseQ <= 1'b1;
        baseQ     <= sample;
        refQ      <= sample;
        cntQ      <= '0;
      end else if (evtFire) begin
        refQ <= sample;
        cntQ <= '0;
      end else begin
        cntQ <= cntNext;
      end
    end
  end
endmodule

// File: rtl/fcm_datapath.sv
module fcm_datapath
  import fcm_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CNT_W    = 16,
  parameter int THRESH   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strb,
  input  logic [SAMPLE_W-1:0] lfSample,
  input  logic                lfValid,
  input  logic [SAMPLE_W-1:0] hfSample,
  input  logic                hfValid,
  output logic                lfPresent,
  output logic                hfPresent,
  output logic                evtValid,
  output logic                evtBand,
  output logic [SAMPLE_W-1:0] evtOldRef,
  output logic [SAMPLE_W-1:0] evtNewRead,
  output logic [CNT_W-1:0]    evtCount
);
  logic [NBANDS-1:0][SAMPLE_W-1:0] smp, bOld, bNew;
  logic [NBANDS-1:0][CNT_W-1:0]    bCnt;
  logic [NBANDS-1:0]               onVec, vld, acc, fire, pres;

  assign smp   = {hfSample, lfSample};
  assign vld   = {hfValid, lfValid};
  assign onVec = {strb.hfOn, strb.lfOn};

  for (genvar b = 0; b < NBANDS; b++) begin : g_band
    assign acc[b] = vld[b] && onVec[b] && !strb.hold;
    fcm_band #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .THRESH(THRESH)) u_band (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (strb.restart),
      .accept   (acc[b]),
      .sample   (smp[b]),
      .present  (pres[b]),
      .evtFire  (fire[b]),
      .evtOld   (bOld[b]),
      .evtNew   (bNew[b]),
      .evtCount (bCnt[b])
    );
  end

  assign lfPresent = pres[0] && onVec[0];
  assign hfPresent = pres[1] && onVec[1];

  // Event merge: LF takes the output, a coincident HF event waits one cycle.
  logic                holdValQ;
  logic [SAMPLE_W-1:0] holdOldQ, holdNewQ;
  logic [CNT_W-1:0]    holdCntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid   <= 1'b0;
      evtBand    <= 1'b0;
      evtOldRef  <= '0;
      evtNewRead <= '0;
      evtCount   <= '0;
      holdValQ   <= 1'b0;
      holdOldQ   <= '0;
      holdNewQ   <= '0;
      holdCntQ   <= '0;
    end else if (holdValQ) begin
      evtValid   <= 1'b1;
      evtBand    <= 1'b1;
      evtOldRef  <= holdOldQ;
      evtNewRead <= holdNewQ;
      evtCount   <= holdCntQ;
      holdValQ   <= 1'b0;
    end else if (fire[0]) begin
      evtValid   <= 1'b1;
      evtBand    <= 1'b0;
      evtOldRef  <= bOld[0];
      evtNewRead <= bNew[0];
      evtCount   <= bCnt[0];
      holdValQ   <= fire[1];
      holdOldQ   <= bOld[1];
      holdNewQ   <= bNew[1];
      holdCntQ   <= bCnt[1];
    end else if (fire[1]) begin
      evtValid   <= 1'b1;
      evtBand    <= 1'b1;
      evtOldRef  <= bOld[1];
      evtNewRead <= bNew[1];
      evtCount   <= bCnt[1];
    end else begin
      evtValid   <= 1'b0;
    end
  end
endmodule

// File: rtl/field_change_monitor.sv
module field_change_monitor
  import fcm_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CNT_W    = 16,
  parameter int THRESH   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                stopReq,
  input  logic [1:0]          bandMode,
  input  logic [SAMPLE_W-1:0] lfSample,
  input  logic                lfValid,
  input  logic [SAMPLE_W-1:0] hfSample,
  input  logic                hfValid,
  output logic                lfPresent,
  output logic                hfPresent,
  output logic                evtValid,
  output logic                evtBand,
  output logic [SAMPLE_W-1:0] evtOldRef,
  output logic [SAMPLE_W-1:0] evtNewRead,
  output logic [CNT_W-1:0]    evtCount
);
  ctlStrobe_t ctlStrb;

  fcm_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stopReq  (stopReq),
    .bandMode (bandMode),
    .strb     (ctlStrb)
  );

  fcm_datapath #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .THRESH(THRESH)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (ctlStrb),
    .lfSample   (lfSample),
    .lfValid    (lfValid),
    .hfSample   (hfSample),
    .hfValid    (hfValid),
    .lfPresent  (lfPresent),
    .hfPresent  (hfPresent),
    .evtValid   (evtValid),
    .evtBand    (evtBand),
    .evtOldRef  (evtOldRef),
    .evtNewRead (evtNewRead),
    .evtCount   (evtCount)
  );
endmodule

// File: rtl/field_change_monitor_chk.sv
module field_change_monitor_chk
  import fcm_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CNT_W    = 16,
  parameter int THRESH   = 10
) (
  input logic                clk,
  input logic                rstN,
  input ctlStrobe_t          strb,
  input logic                lfPresent,
  input logic                hfPresent,
  input logic                evtValid,
  input logic                evtBand,
  input logic [SAMPLE_W-1:0] evtOldRef,
  input logic [SAMPLE_W-1:0] evtNewRead,
  input logic [CNT_W-1:0]    evtCount
);
  logic [SAMPLE_W:0] evtGap;
  assign evtGap = ({1'b0, evtOldRef} >= {1'b0, evtNewRead}) ?
                  ({1'b0, evtOldRef} - {1'b0, evtNewRead}) :
                  ({1'b0, evtNewRead} - {1'b0, evtOldRef});

  // R1: a restart leaves no presence in the next cycle
  a_r1_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> !lfPresent && !hfPresent);

  // R6: a stop turns both bands off and drops presence
  a_r6_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hold && !strb.restart) |=> !strb.lfOn && !strb.hfOn && !lfPresent && !hfPresent);

  // R7: a band that is off shows no presence
  a_r7_lf_gate: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lfOn |-> !lfPresent);
  a_r7_hf_gate: assert property (@(posedge clk) disable iff (!rstN)
    !strb.hfOn |-> !hfPresent);

  // R7: events only come from a band that was on
  a_r7_lf_event_on: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtBand) |-> $past(strb.lfOn));
  a_r7_hf_event_on: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtBand) |-> $past(strb.hfOn));

  // R4: every event jumps by more than the threshold
  a_r4_event_gap: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtGap > (SAMPLE_W+1)'(THRESH)));

  // R3: an event always counts the reading that caused it
  a_r3_count_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtCount != '0));
endmodule

bind field_change_monitor field_change_monitor_chk #(
  .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .THRESH(THRESH)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strb       (ctlStrb),
  .lfPresent  (lfPresent),
  .hfPresent  (hfPresent),
  .evtValid   (evtValid),
  .evtBand    (evtBand),
  .evtOldRef  (evtOldRef),
  .evtNewRead (evtNewRead),
  .evtCount   (evtCount)
);

// File: tb/test_field_change_monitor.sv
module test_field_change_monitor;
  localparam int SW = 10;
  localparam int CW = 4;
  localparam int TH = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0, stopReq = 1'b0;
  logic [1:0]    bandMode = 2'b00;
  logic [SW-1:0] lfSample = '0, hfSample = '0;
  logic          lfValid = 1'b0, hfValid = 1'b0;
  logic          lfPresent, hfPresent, evtValid, evtBand;
  logic [SW-1:0] evtOldRef, evtNewRead;
  logic [CW-1:0] evtCount;

  always #2 clk = ~clk;

  field_change_monitor #(.SAMPLE_W(SW), .CNT_W(CW), .THRESH(TH)) i_field_change_monitor (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq), .bandMode(bandMode),
    .lfSample(lfSample), .lfValid(lfValid), .hfSample(hfSample), .hfValid(hfValid),
    .lfPresent(lfPresent), .hfPresent(hfPresent), .evtValid(evtValid), .evtBand(evtBand),
    .evtOldRef(evtOldRef), .evtNewRead(evtNewRead), .evtCount(evtCount)
  );

  int    checks = 0, errors = 0;
  string curTag = "R9";

  // reference model state
  bit mRun = 0;
  int mMode = 0;
  bit mHave[2];
  int mBase[2], mRef[2], mCnt[2];
  bit mOutV = 0, mOutB = 0, mHoldV = 0;
  int mOutOld = 0, mOutNew = 0, mOutCnt = 0, mHoldOld = 0, mHoldNew = 0, mHoldCnt = 0;

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int clampS(int x);
    return (x < 0) ? 0 : ((x > 1023) ? 1023 : x);
  endfunction

  function automatic bit bandOn(int b);
    return mRun && ((b == 0) ? (mMode != 2) : (mMode != 1));
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", curTag, what, act, exp);
    end
  endtask

  task automatic modelEdge(bit lv, int ls, bit hv, int hs, bit st, bit sp, int md);
    bit fire[2];
    int fOld[2], fNew[2], fCnt[2], s[2];
    bit v[2];
    v[0] = lv; v[1] = hv; s[0] = ls; s[1] = hs;
    for (int b = 0; b < 2; b++) begin
      fire[b] = 0; fOld[b] = 0; fNew[b] = 0; fCnt[b] = 0;
      if (!(st || sp) && v[b] && bandOn(b)) begin
        if (!mHave[b]) begin
          mHave[b] = 1; mBase[b] = s[b]; mRef[b] = s[b]; mCnt[b] = 0;
        end else begin
          int c;
          c = (mCnt[b] == CMAX) ? CMAX : mCnt[b] + 1;
          if (iabs(s[b] - mRef[b]) > TH) begin
            fire[b] = 1; fOld[b] = mRef[b]; fNew[b] = s[b]; fCnt[b] = c;
            mRef[b] = s[b]; mCnt[b] = 0;
          end else mCnt[b] = c;
        end
      end
    end
    if (mHoldV) begin
      mOutV = 1; mOutB = 1; mOutOld = mHoldOld; mOutNew = mHoldNew; mOutCnt = mHoldCnt;
      mHoldV = 0;
    end else if (fire[0]) begin
      mOutV = 1; mOutB = 0; mOutOld = fOld[0]; mOutNew = fNew[0]; mOutCnt = fCnt[0];
      mHoldV = fire[1]; mHoldOld = fOld[1]; mHoldNew = fNew[1]; mHoldCnt = fCnt[1];
    end else if (fire[1]) begin
      mOutV = 1; mOutB = 1; mOutOld = fOld[1]; mOutNew = fNew[1]; mOutCnt = fCnt[1];
    end else mOutV = 0;
    if (sp) mRun = 0;
    else if (st) begin
      mRun = 1; mMode = md;
      for (int b = 0; b < 2; b++) begin mHave[b] = 0; mCnt[b] = 0; end
    end
  endtask

  task automatic compareAll();
    bit eL, eH;
    eL = bandOn(0) && mHave[0] && (iabs(mRef[0] - mBase[0]) > TH);
    eH = bandOn(1) && mHave[1] && (iabs(mRef[1] - mBase[1]) > TH);
    chk(evtValid == mOutV, "evtValid", int'(evtValid), int'(mOutV));
    if (mOutV && evtValid) begin
      chk(evtBand == mOutB, "evtBand", int'(evtBand), int'(mOutB));
      chk(int'(evtOldRef) == mOutOld, "evtOldRef", int'(evtOldRef), mOutOld);
      chk(int'(evtNewRead) == mOutNew, "evtNewRead", int'(evtNewRead), mOutNew);
      chk(int'(evtCount) == mOutCnt, "evtCount", int'(evtCount), mOutCnt);
    end
    chk(lfPresent == eL, "lfPresent", int'(lfPresent), int'(eL));
    chk(hfPresent == eH, "hfPresent", int'(hfPresent), int'(eH));
  endtask

  task automatic step(bit lv, int ls, bit hv, int hs, bit st = 0, bit sp = 0, int md = 0);
    lfValid = lv; lfSample = SW'(ls); hfValid = hv; hfSample = SW'(hs);
    startReq = st; stopReq = sp; bandMode = 2'(md);
    @(posedge clk);
    modelEdge(lv, ls, hv, hs, st, sp, md);
    @(negedge clk);
    compareAll();
  endtask

  // one reading pair then an idle cycle (strobes never back to back)
  task automatic rd(bit lv, int ls, bit hv, int hs);
    step(lv, ls, hv, hs);
    step(0, 0, 0, 0);
  endtask

  task automatic startMode(int md);
    step(0, 0, 0, 0, 1, 0, md);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int b = 0; b < 2; b++) begin mHave[b] = 0; mBase[b] = 0; mRef[b] = 0; mCnt[b] = 0; end
    repeat (3) @(negedge clk);
    curTag = "R9"; // reset state
    compareAll();
    rstN = 1'b1;
    rd(1, 100, 1, 100);
    rd(1, 900, 1, 10);   // R9: ignored before any start
    rd(1, 0, 1, 1023);

    curTag = "R1"; // baseline capture, readings in the start cycle dropped
    step(1, 700, 1, 700, 1, 0, 0);
    step(0, 0, 0, 0);
    rd(1, 100, 1, 200);
    curTag = "R4"; // exactly THRESH: no event, no presence
    rd(1, 110, 1, 190);
    curTag = "R3"; // counter includes both readings
    rd(1, 121, 0, 0);
    curTag = "R2"; // presence follows the moved reference
    rd(1, 125, 0, 0);
    curTag = "R5"; // compared with the new reference 121
    rd(1, 100, 0, 0);
    rd(1, 132, 0, 0);
    curTag = "R8"; // coincident events: LF then HF
    rd(1, 300, 1, 500);
    rd(1, 10, 1, 10);
    step(1, 600, 1, 600);
    step(0, 0, 0, 0);
    step(1, 60, 1, 60);
    step(0, 0, 0, 0);

    curTag = "R6"; // stop clears presence and ignores readings
    step(0, 0, 0, 0, 0, 1, 0);
    rd(1, 900, 1, 900);
    step(1, 10, 1, 10, 1, 1, 0); // stop beats start
    rd(1, 500, 1, 500);

    curTag = "R7"; // LF only
    startMode(1);
    rd(1, 300, 1, 300);
    rd(1, 300, 1, 900);
    rd(1, 350, 1, 100);
    curTag = "R7"; // HF only
    startMode(2);
    rd(1, 300, 1, 300);
    rd(1, 800, 1, 320);
    rd(1, 0, 1, 340);
    curTag = "R7"; // both, alternate encoding
    startMode(3);
    rd(1, 0, 1, 1023);
    curTag = "R4"; // full-scale jumps
    rd(1, 1023, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);

    curTag = "R3"; // saturation
    startMode(0);
    rd(1, 500, 1, 500);
    for (int k = 0; k < 20; k++) rd(1, (k % 2) ? 502 : 498, 1, 500);
    rd(1, 520, 1, 500);
    rd(1, 540, 1, 560);

    curTag = "R1"; // restart while running recaptures baselines
    startMode(0);
    rd(1, 800, 1, 40);
    rd(1, 805, 1, 45);

    curTag = "R4"; // constrained random walk
    begin
      int lc, hc;
      bit lp, hp;
      lc = 500; hc = 500; lp = 0; hp = 0;
      startMode(0);
      for (int k = 0; k < 6000; k++) begin
        bit lv, hv, st, sp;
        int r, md;
        r  = int'($urandom_range(0, 299));
        st = (r == 0) || (r == 2);
        sp = (r == 1) || (r == 2);
        md = int'($urandom_range(0, 3));
        lv = !lp && ($urandom_range(0, 1) == 0);
        hv = !hp && ($urandom_range(0, 1) == 0);
        if ($urandom_range(0, 15) == 0) lc = int'($urandom_range(0, 1023));
        else lc = clampS(lc + int'($urandom_range(0, 26)) - 13);
        if ($urandom_range(0, 15) == 0) hc = int'($urandom_range(0, 1023));
        else hc = clampS(hc + int'($urandom_range(0, 26)) - 13);
        step(lv, lc, hv, hc, st, sp, md);
        lp = lv; hp = hv;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule